// File: doc/BRIEF.md
# Sleep Control Register with SMI Trap

This block is a small I/O-mapped power-management control slice. Software programs a sleep-control register with a sleep-type code and an SCI enable, then writes a trigger bit in that register to ask for sleep entry. A second register controls whether that trigger write goes ahead or is intercepted. When interception is on, the write raises the active-low SMI# line and the sleep request is suppressed, so firmware can run its own code before the system powers down.

The register port is a single-cycle write strobe with a combinational read path. The sleep side produces a one-cycle request pulse. The sleep type is captured from the same write that set the trigger. Two decoded pulses mark the soft-off and hibernate codes. The SMI side latches a trap status and holds SMI# low until firmware writes end-of-SMI.

Top module: `pm_sleep_trap`

## Requirements
- R1: After reset, all three registers read 0, `smi_n` is 1, and `sleep_req`, `sleep_poweroff`, `sleep_hibernate` and `sleep_type` are 0.
- R2: The sleep-control register at offset 0x04 stores the sleep type in bits 12:10 and the SCI enable in bit 0, and reads them back. Bit 13, the trigger, always reads 0.
- R3: With the trap enable at 0, a write to 0x04 with bit 13 set pulses `sleep_req` for exactly one cycle, starting the cycle after the write. `sleep_type` then carries bits 12:10 of that same write, and `smi_n` stays 1.
- R4: With the trap enable (bit 4 of offset 0x30) at 1, a trigger write produces no `sleep_req` and leaves `sleep_type` unchanged. It sets the trap status (bit 4 of offset 0x34). If the global SMI enable (bit 0 of 0x30) is 1, `smi_n` goes to 0 in the cycle after the write.
- R5: With the global SMI enable at 0, a trapped trigger write still sets the trap status and suppresses sleep, but `smi_n` stays 1.
- R6: Writing 1 to bit 1 of 0x30 (end-of-SMI) drives `smi_n` to 1 and clears the trap status from the next cycle. Bit 1 reads back as 0. The same write also updates bits 4 and 0.
- R7: A second trapped trigger write while `smi_n` is 0 keeps it at 0. A single end-of-SMI write then releases it.
- R8: A write to 0x04 with bit 13 at 0 updates the fields but causes no sleep request and no SMI.
- R9: `sleep_poweroff` pulses together with `sleep_req` when the captured type is 3'b111 (soft-off). `sleep_hibernate` pulses together with `sleep_req` when the type is 3'b110 (hibernate). At most one of them is high at a time.
- R10: Writes to offsets other than 0x04 and 0x30, including the read-only status at 0x34, change no state and no output. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset from the block base |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sleep_req | output | 1 | One-cycle sleep-entry request |
| sleep_type | output | 3 | Sleep type captured from the trigger write |
| sleep_poweroff | output | 1 | Request pulse qualified by the soft-off type |
| sleep_hibernate | output | 1 | Request pulse qualified by the hibernate type |
| smi_n | output | 1 | Active-low SMI# |

## Verification
Two functions share one cycle in this block. First, loading the type field and firing the trigger happen in the same write, so the bench first stores one type without the trigger and then triggers with a different type. It judges that `sleep_type` reports the type from the trigger write and not the stored one. Second, a trapped trigger arrives while SMI# is already held low, and the trap-status set and the SMI# hold must both stand; the bench confirms that one end-of-SMI releases both. The bench also checks the cycle after each write, so that a trapped write never leaks a request pulse.

// File: rtl/pm_trap_pkg.sv
package pm_trap_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int TYP_W  = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SMIEN  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_SMISTS = 8'h34;

  localparam int CTRL_SCI_B  = 0;
  localparam int CTRL_TYP_LO = 10;
  localparam int CTRL_TRIG_B = 13;
  localparam int EN_GBL_B    = 0;
  localparam int EN_EOS_B    = 1;
  localparam int EN_TRAP_B   = 4;
  localparam int STS_TRAP_B  = 4;

  localparam logic [TYP_W-1:0] TYP_HIBERNATE = 3'b110;
  localparam logic [TYP_W-1:0] TYP_SOFTOFF   = 3'b111;

  function automatic logic [DATA_W-1:0] ctrl_image(logic [TYP_W-1:0] typ, logic sci);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTRL_TYP_LO +: TYP_W] = typ;
    w[CTRL_SCI_B] = sci;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] smien_image(logic trap_en, logic gbl);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_TRAP_B] = trap_en;
    w[EN_GBL_B]  = gbl;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] sts_image(logic sts);
    logic [DATA_W-1:0] w;
    w = '0;
    w[STS_TRAP_B] = sts;
    return w;
  endfunction

  function automatic logic is_softoff(logic [TYP_W-1:0] typ);
    return typ == TYP_SOFTOFF;
  endfunction

  function automatic logic is_hibernate(logic [TYP_W-1:0] typ);
    return typ == TYP_HIBERNATE;
  endfunction
endpackage

// File: rtl/pm_trap_decode.sv
module pm_trap_decode
  import pm_trap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [TYP_W-1:0]  typ_q,
  input  logic              sci_q,
  input  logic              trap_en_q,
  input  logic              gbl_q,
  input  logic              sts_q,
  output logic              ctrl_wr,
  output logic              smien_wr,
  output logic [DATA_W-1:0] rdata
);
  assign ctrl_wr  = wr && (addr == OFS_CTRL);
  assign smien_wr = wr && (addr == OFS_SMIEN);

  always_comb begin
    unique case (addr)
      OFS_CTRL:   rdata = ctrl_image(typ_q, sci_q);
      OFS_SMIEN:  rdata = smien_image(trap_en_q, gbl_q);
      OFS_SMISTS: rdata = sts_image(sts_q);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/pm_sleep_ctl.sv
module pm_sleep_ctl
  import pm_trap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [TYP_W-1:0] wr_typ,
  input  logic             wr_sci,
  input  logic             wr_trig,
  input  logic             trap_en,
  output logic [TYP_W-1:0] typ_q,
  output logic             sci_q,
  output logic             trig_wr,
  output logic             sleep_fire,
  output logic             sleep_req,
  output logic [TYP_W-1:0] sleep_type,
  output logic             sleep_poweroff,
  output logic             sleep_hibernate
);
  assign trig_wr    = ctrl_wr && wr_trig;
  assign sleep_fire = trig_wr && !trap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ_q <= '0;
      sci_q <= 1'b0;
    end else if (ctrl_wr) begin
      typ_q <= wr_typ;
      sci_q <= wr_sci;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_req       <= 1'b0;
      sleep_type      <= '0;
      sleep_poweroff  <= 1'b0;
      sleep_hibernate <= 1'b0;
    end else begin
      sleep_req       <= sleep_fire;
      sleep_poweroff  <= sleep_fire && is_softoff(wr_typ);
      sleep_hibernate <= sleep_fire && is_hibernate(wr_typ);
      if (sleep_fire) sleep_type <= wr_typ;
    end
  end
endmodule

// File: rtl/pm_smi_ctl.sv
module pm_smi_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic smien_wr,
  input  logic wr_gbl,
  input  logic wr_eos,
  input  logic wr_trap,
  input  logic trig_wr,
  output logic trap_en_q,
  output logic gbl_q,
  output logic sts_q,
  output logic trap_hit,
  output logic eos_wr,
  output logic smi_n
);
  logic smi_act_q;

  assign trap_hit = trig_wr && trap_en_q;
  assign eos_wr   = smien_wr && wr_eos;
  assign smi_n    = !smi_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_en_q <= 1'b0;
      gbl_q     <= 1'b0;
    end else if (smien_wr) begin
      trap_en_q <= wr_trap;
      gbl_q     <= wr_gbl;
    end
  end

  // a new trap takes priority over a release in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q     <= 1'b0;
      smi_act_q <= 1'b0;
    end else begin
      if (trap_hit)    sts_q <= 1'b1;
      else if (eos_wr) sts_q <= 1'b0;
      if (trap_hit && gbl_q) smi_act_q <= 1'b1;
      else if (eos_wr)       smi_act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_sleep_trap.sv
module pm_sleep_trap
  import pm_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sleep_req,
  output logic [TYP_W-1:0]  sleep_type,
  output logic              sleep_poweroff,
  output logic              sleep_hibernate,
  output logic              smi_n
);
  logic             ctrl_wr, smien_wr;
  logic [TYP_W-1:0] typ_q;
  logic             sci_q, trap_en_q, gbl_q, sts_q;
  logic             trig_wr, sleep_fire, trap_hit, eos_wr;
  logic             unused_wdata;

  assign unused_wdata = ^{reg_wdata[DATA_W-1:CTRL_TRIG_B+1],
                          reg_wdata[CTRL_TYP_LO-1:EN_TRAP_B+1],
                          reg_wdata[EN_TRAP_B-1:EN_EOS_B+1]};

  pm_trap_decode u_dec (
    .addr      (reg_addr),
    .wr        (reg_wr),
    .typ_q     (typ_q),
    .sci_q     (sci_q),
    .trap_en_q (trap_en_q),
    .gbl_q     (gbl_q),
    .sts_q     (sts_q),
    .ctrl_wr   (ctrl_wr),
    .smien_wr  (smien_wr),
    .rdata     (reg_rdata)
  );

  pm_sleep_ctl u_sleep (
    .clk             (clk),
    .rst_n           (rst_n),
    .ctrl_wr         (ctrl_wr),
    .wr_typ          (reg_wdata[CTRL_TYP_LO +: TYP_W]),
    .wr_sci          (reg_wdata[CTRL_SCI_B]),
    .wr_trig         (reg_wdata[CTRL_TRIG_B]),
    .trap_en         (trap_en_q),
    .typ_q           (typ_q),
    .sci_q           (sci_q),
    .trig_wr         (trig_wr),
    .sleep_fire      (sleep_fire),
    .sleep_req       (sleep_req),
    .sleep_type      (sleep_type),
    .sleep_poweroff  (sleep_poweroff),
    .sleep_hibernate (sleep_hibernate)
  );

  pm_smi_ctl u_smi (
    .clk       (clk),
    .rst_n     (rst_n),
    .smien_wr  (smien_wr),
    .wr_gbl    (reg_wdata[EN_GBL_B]),
    .wr_eos    (reg_wdata[EN_EOS_B]),
    .wr_trap   (reg_wdata[EN_TRAP_B]),
    .trig_wr   (trig_wr),
    .trap_en_q (trap_en_q),
    .gbl_q     (gbl_q),
    .sts_q     (sts_q),
    .trap_hit  (trap_hit),
    .eos_wr    (eos_wr),
    .smi_n     (smi_n)
  );
endmodule

// File: rtl/pm_sleep_trap_chk.sv
module pm_sleep_trap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic [2:0] sleep_type,
  input logic       sleep_poweroff,
  input logic       sleep_hibernate,
  input logic       smi_n,
  input logic       sleep_fire,
  input logic       trap_hit,
  input logic       eos_wr,
  input logic       gbl_q
);
  // R3
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> $past(sleep_fire));
  // R4
  trap_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_hit && gbl_q) |=> !smi_n);
  // R4
  trap_no_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> !sleep_req);
  // R5
  gbl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_n && !(trap_hit && gbl_q)) |=> smi_n);
  // R6
  eos_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_wr && !trap_hit) |=> smi_n);
  // R7
  smi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smi_n && !eos_wr) |=> !smi_n);
  // R9
  poweroff_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_poweroff |-> (sleep_req && sleep_type == 3'b111));
  // R9
  hibernate_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_hibernate |-> (sleep_req && sleep_type == 3'b110));
  // R9
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sleep_poweroff, sleep_hibernate}));
endmodule

bind pm_sleep_trap pm_sleep_trap_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sleep_req       (sleep_req),
  .sleep_type      (sleep_type),
  .sleep_poweroff  (sleep_poweroff),
  .sleep_hibernate (sleep_hibernate),
  .smi_n           (smi_n),
  .sleep_fire      (sleep_fire),
  .trap_hit        (trap_hit),
  .eos_wr          (eos_wr),
  .gbl_q           (gbl_q)
);

// File: tb/pm_sleep_trap_test.sv
module pm_sleep_trap_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TRIG = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sleep_req, sleep_poweroff, sleep_hibernate, smi_n;
  logic [2:0]  sleep_type;
  int checks = 0;
  int errors = 0;

  pm_sleep_trap uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
    .sleep_type(sleep_type), .sleep_poweroff(sleep_poweroff),
    .sleep_hibernate(sleep_hibernate), .smi_n(smi_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] typ_bits(logic [2:0] t);
    return {19'd0, t, 10'd0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write lands at one posedge; returns at the following negedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic t_reset;
    check("R1 smi_n", {31'd0, smi_n}, 32'd1);
    check("R1 sleep_req", {31'd0, sleep_req}, 32'd0);
    check("R1 sleep_type", {29'd0, sleep_type}, 32'd0);
    check("R1 pulses", {30'd0, sleep_poweroff, sleep_hibernate}, 32'd0);
    rd("R1 ctrl", 8'h04, 32'd0);
    rd("R1 smien", 8'h30, 32'd0);
    rd("R1 sts", 8'h34, 32'd0);
  endtask

  task automatic t_ctrl_fields;
    wr(8'h04, typ_bits(3'b101) | 32'd1);
    check("R8 no req", {31'd0, sleep_req}, 32'd0);
    check("R8 no smi", {31'd0, smi_n}, 32'd1);
    rd("R2 readback", 8'h04, 32'h0000_1401);
    wr(8'h04, TRIG | typ_bits(3'b011) | 32'd1);
    check("R3 req", {31'd0, sleep_req}, 32'd1);
    check("R3 type", {29'd0, sleep_type}, 32'd3);
    check("R3 smi_n", {31'd0, smi_n}, 32'd1);
    rd("R2 trig reads 0", 8'h04, 32'h0000_0C01);
    @(negedge clk);
    check("R3 one cycle", {31'd0, sleep_req}, 32'd0);
  endtask

  task automatic t_state_codes;
    wr(8'h04, TRIG | typ_bits(3'b110));
    check("R9 hib req", {31'd0, sleep_req}, 32'd1);
    check("R9 hib", {30'd0, sleep_poweroff, sleep_hibernate}, 32'd1);
    wr(8'h04, TRIG | typ_bits(3'b111));
    check("R9 off req", {31'd0, sleep_req}, 32'd1);
    check("R9 off", {30'd0, sleep_poweroff, sleep_hibernate}, 32'd2);
    check("R9 off type", {29'd0, sleep_type}, 32'd7);
    @(negedge clk);
    check("R9 pulse end", {29'd0, sleep_req, sleep_poweroff, sleep_hibernate}, 32'd0);
  endtask

  task automatic t_type_same_write;
    wr(8'h04, typ_bits(3'b010));
    check("R8 store only", {31'd0, sleep_req}, 32'd0);
    wr(8'h04, TRIG | typ_bits(3'b101));
    check("R3 same write type", {29'd0, sleep_type}, 32'd5);
    check("R3 same write req", {31'd0, sleep_req}, 32'd1);
  endtask

  task automatic t_trap_gbl;
    wr(8'h30, 32'h11);
    rd("R6 en readback", 8'h30, 32'h11);
    wr(8'h04, TRIG | typ_bits(3'b111));
    check("R4 smi low", {31'd0, smi_n}, 32'd0);
    check("R4 no req", {31'd0, sleep_req}, 32'd0);
    check("R4 type kept", {29'd0, sleep_type}, 32'd5);
    rd("R4 sts", 8'h34, 32'h10);
    @(negedge clk);
    check("R4 no late req", {31'd0, sleep_req}, 32'd0);
    wr(8'h04, TRIG | typ_bits(3'b110));
    check("R7 still low", {31'd0, smi_n}, 32'd0);
    check("R7 no req", {31'd0, sleep_req}, 32'd0);
    wr(8'h30, 32'h13);
    check("R6 released", {31'd0, smi_n}, 32'd1);
    rd("R6 sts clear", 8'h34, 32'd0);
    rd("R6 eos reads 0", 8'h30, 32'h11);
    @(negedge clk);
    check("R6 stays high", {31'd0, smi_n}, 32'd1);
  endtask

  task automatic t_trap_nogbl;
    wr(8'h30, 32'h10);
    wr(8'h04, TRIG | typ_bits(3'b111));
    check("R5 smi high", {31'd0, smi_n}, 32'd1);
    check("R5 no req", {31'd0, sleep_req}, 32'd0);
    rd("R5 sts", 8'h34, 32'h10);
    wr(8'h30, 32'h02);
    rd("R6 sts clear", 8'h34, 32'd0);
    rd("R6 en cleared", 8'h30, 32'd0);
    wr(8'h04, TRIG | typ_bits(3'b110));
    check("R3 untrapped again", {31'd0, sleep_req}, 32'd1);
  endtask

  task automatic t_unmapped;
    wr(8'h04, typ_bits(3'b001));
    wr(8'h08, 32'hFFFF_FFFF);
    check("R10 no req", {31'd0, sleep_req}, 32'd0);
    check("R10 no smi", {31'd0, smi_n}, 32'd1);
    rd("R10 read 0", 8'h08, 32'd0);
    rd("R10 ctrl kept", 8'h04, 32'h0000_0400);
    wr(8'h34, 32'hFFFF_FFFF);
    rd("R10 sts ro", 8'h34, 32'd0);
    rd("R10 en kept", 8'h30, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_fields();
    t_state_codes();
    t_type_same_write();
    t_trap_gbl();
    t_trap_nogbl();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule